// File: doc/BRIEF.md
# Serial DAC Frame Receiver

This block is the digital input stage of a three-wire serial DAC. A host lowers an active-low frame-select line, then clocks 24 data bits, most significant first, on a serial clock. The receiver captures each bit on a falling edge of that clock. Once the frame is complete it moves the 18-bit conversion code into a held DAC register. The analog converter that follows reads only that register.

All logic runs on a fast system clock. The three serial pins pass through two-flop synchronizers, and the block detects their edges in the system domain. The system clock must run at least four times faster than the serial clock. If frame-select rises before the 24th falling edge, the block discards the partial frame and the held code stays as it was. A parameter sets the power-up value of the register to zero or to midscale. On each commit the block gives a one-cycle strobe. A flag shows whether the committed frame carried a nonzero reserved field; such a frame is still accepted.

Top module: `sdac_frame_rx`

## Requirements
- R1: While reset is asserted, and after it until the first complete frame, `dac_code` is 0 when `RESET_MID`=0 and 0x20000 when `RESET_MID`=1. `dac_update` and `rsv_flag` are 0.
- R2: A frame starts only on a falling edge of `fsel_n`. Serial clock edges while `fsel_n` is high leave every output unchanged.
- R3: Bits are taken on falling edges of `sclk`, MSB first. Frame bit 23 arrives first and bit 0 last. The committed code is frame bits 19:2. The same rule holds for the all-zero and all-one codes.
- R4: The 24th falling edge of a frame loads the code. `dac_code` changes on the third rising system-clock edge after that edge is first seen at the pin, and `dac_update` is high for exactly that one cycle.
- R5: If `fsel_n` rises after fewer than 24 falling edges, including after 23, there is no strobe and `dac_code` keeps its value. The next frame decodes with no leftover bits from the aborted one.
- R6: Falling edges of `sclk` after the 24th, while `fsel_n` stays low, change nothing. Only one strobe is given per low period of `fsel_n`.
- R7: After a commit, `dac_code` holds its value whether `fsel_n` stays low or goes high. It changes only in a cycle where `dac_update` is high.
- R8: `rsv_flag` is loaded on each commit. It is 1 when frame bits 21:20 are nonzero and 0 otherwise, and the frame is committed in both cases. Frame bits 23:22 and 1:0 have no effect on any output.
- R9: `dac_update` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsel_n | input | 1 | Frame-select from the host, active low |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sdin | input | 1 | Serial data, MSB first |
| dac_code | output | 18 | Held DAC code |
| dac_update | output | 1 | One-cycle strobe when `dac_code` is loaded |
| rsv_flag | output | 1 | Reserved field of the last committed frame was nonzero |

## Verification
The assertions check every cycle that the held code and the flag move only together with the strobe, and that the strobe never lasts two cycles. They also check that a detected 24th edge always produces a strobe and that an abort never does. The controller state is checked too: it stays idle without a frame-select fall, it stays in its hold state while frame-select remains low, and it clears its count on an abort. Other behaviours need the bench's scenarios with complete data patterns. These are the bit ordering and field position of the code, leftover data after an abort at 23 bits, the extra clocks after the 24th, and the midscale reset variant.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  // Receiver control states
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,  // waiting for a frame-select fall
    RX_SHIFT = 2'd1,  // collecting bits
    RX_HOLD  = 2'd2   // frame done, waiting for frame-select to rise
  } rx_state_e;

  // Bit positions of the serial pins inside the synchronized vector
  localparam int PIN_FSEL = 0;
  localparam int PIN_SCLK = 1;
  localparam int PIN_DIN  = 2;
  localparam int PIN_CNT  = 3;

  // Idle levels loaded into the synchronizers at reset: select and clock high
  localparam logic [PIN_CNT-1:0] PIN_IDLE = 3'b011;

endpackage

// File: rtl/sdac_pin_sync.sv
module sdac_pin_sync #(
  parameter int             WIDTH   = 3,
  parameter int             STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins_i,
  output logic [WIDTH-1:0] lvl_o
);

  // One flop chain per pin; the last stage is the synchronized level
  for (genvar b = 0; b < WIDTH; b++) begin : g_pin
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= {STAGES{RST_VAL[b]}};
      end else begin
        chain <= {chain[STAGES-2:0], pins_i[b]};
      end
    end

    assign lvl_o[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/sdac_edge_det.sv
module sdac_edge_det #(
  parameter int               WIDTH   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] fall_o
);

  logic [WIDTH-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= RST_VAL;
    end else begin
      lvl_q <= lvl_i;
    end
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_fall
    assign fall_o[b] = lvl_q[b] & ~lvl_i[b];
  end

endmodule

// File: rtl/sdac_frame_ctrl.sv
module sdac_frame_ctrl
  import sdac_pkg::*;
#(
  parameter int FRAME_BITS = 24,
  parameter int CODE_LSB   = 2,
  parameter int CODE_W     = 18,
  parameter int RSV_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsel_lvl,
  input  logic              fsel_fall,
  input  logic              sclk_fall,
  input  logic              din_bit,
  output logic              commit_o,
  output logic              abort_o,
  output logic [CODE_W-1:0] code_o,
  output logic [RSV_W-1:0]  rsv_o
);

  // The reserved field sits just above the code. Bits above it are never needed.
  localparam int RSV_LSB = CODE_LSB + CODE_W;
  localparam int SH_W    = RSV_LSB + RSV_W - 1;
  localparam int CNT_W   = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [SH_W-1:0]   shreg;
  logic [SH_W:0]     frame_full;

  logic              in_shift;
  logic              last_fall;
  logic              shift_en;

  // Frame as it stands once the current data bit is taken
  assign frame_full = {shreg, din_bit};

  assign in_shift  = (state == RX_SHIFT);
  // The 24th fall counts even if frame-select is seen high in the same cycle
  assign last_fall = in_shift && sclk_fall && (cnt == LAST_IDX);
  assign abort_o   = in_shift && fsel_lvl && !last_fall;
  assign shift_en  = in_shift && sclk_fall && !fsel_lvl && !last_fall;
  assign commit_o  = last_fall;

  assign code_o = frame_full[CODE_LSB +: CODE_W];
  assign rsv_o  = frame_full[RSV_LSB +: RSV_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RX_IDLE;
      cnt   <= '0;
      shreg <= '0;
    end else begin
      unique case (state)
        RX_IDLE: begin
          if (fsel_fall) begin
            state <= RX_SHIFT;
            cnt   <= '0;
            shreg <= '0;
          end
        end
        RX_SHIFT: begin
          if (last_fall) begin
            state <= RX_HOLD;
          end else if (abort_o) begin
            state <= RX_IDLE;
            cnt   <= '0;
            shreg <= '0;
          end else if (shift_en) begin
            cnt   <= cnt + CNT_W'(1);
            shreg <= frame_full[SH_W-1:0];
          end
        end
        RX_HOLD: begin
          if (fsel_lvl) begin
            state <= RX_IDLE;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  // Idle waits for a select fall (R2)
  assert_idle_waits_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_IDLE && !fsel_fall) |=> (state == RX_IDLE));

  // A completed frame moves to the hold state (R4)
  assert_commit_enters_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> (state == RX_HOLD));

  // The bit count never passes the last index while shifting (R4)
  assert_count_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_shift |-> (cnt <= LAST_IDX));

  // An abort leaves a clean controller (R5)
  assert_abort_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> (state == RX_IDLE && cnt == '0 && shreg == '0));

  // Hold ignores the serial clock while select stays low (R6)
  assert_hold_ignores_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_HOLD && !fsel_lvl) |=> (state == RX_HOLD));

endmodule

// File: rtl/sdac_code_hold.sv
module sdac_code_hold #(
  parameter int CODE_W    = 18,
  parameter int RSV_W     = 2,
  parameter bit RESET_MID = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [RSV_W-1:0]  rsv_i,
  output logic [CODE_W-1:0] code_o,
  output logic              update_o,
  output logic              rsv_flag_o
);

  // Power-up code: zero, or only the top bit set for midscale
  function automatic logic [CODE_W-1:0] power_up_code(input bit mid);
    logic [CODE_W-1:0] v;
    v = '0;
    if (mid) begin
      v[CODE_W-1] = 1'b1;
    end
    return v;
  endfunction

  // A reserved field counts as used when any of its bits is set
  function automatic logic rsv_used(input logic [RSV_W-1:0] r);
    return |r;
  endfunction

  localparam logic [CODE_W-1:0] CODE_RST = power_up_code(RESET_MID);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_o     <= CODE_RST;
      update_o   <= 1'b0;
      rsv_flag_o <= 1'b0;
    end else begin
      update_o <= commit_i;
      if (commit_i) begin
        code_o     <= code_i;
        rsv_flag_o <= rsv_used(rsv_i);
      end
    end
  end

  // The held code moves only together with the strobe (R7)
  assert_code_only_on_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !update_o |-> $stable(code_o));

  // The reserved flag moves only together with the strobe (R8)
  assert_flag_only_on_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !update_o |-> $stable(rsv_flag_o));

  // The strobe lasts one cycle (R9)
  assert_single_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    update_o |=> !update_o);

endmodule

// File: rtl/sdac_frame_rx.sv
module sdac_frame_rx
  import sdac_pkg::*;
#(
  parameter int FRAME_BITS  = 24,
  parameter int CODE_LSB    = 2,
  parameter int CODE_W      = 18,
  parameter int RSV_W       = 2,
  parameter int SYNC_STAGES = 2,
  parameter bit RESET_MID   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsel_n,
  input  logic              sclk,
  input  logic              sdin,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_update,
  output logic              rsv_flag
);

  localparam int EDGE_W = 2;

  logic [PIN_CNT-1:0] pins_raw;
  logic [PIN_CNT-1:0] pins_lvl;
  logic [EDGE_W-1:0]  pin_fall;

  // Named internal events
  logic              fsel_lvl;
  logic              fsel_fall;
  logic              sclk_fall;
  logic              din_bit;
  logic              frame_commit;
  logic              frame_abort;
  logic [CODE_W-1:0] frame_code;
  logic [RSV_W-1:0]  frame_rsv;

  assign pins_raw[PIN_FSEL] = fsel_n;
  assign pins_raw[PIN_SCLK] = sclk;
  assign pins_raw[PIN_DIN]  = sdin;

  sdac_pin_sync #(
    .WIDTH   (PIN_CNT),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_IDLE)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pins_i (pins_raw),
    .lvl_o  (pins_lvl)
  );

  sdac_edge_det #(
    .WIDTH   (EDGE_W),
    .RST_VAL (PIN_IDLE[EDGE_W-1:0])
  ) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (pins_lvl[EDGE_W-1:0]),
    .fall_o (pin_fall)
  );

  assign fsel_lvl  = pins_lvl[PIN_FSEL];
  assign din_bit   = pins_lvl[PIN_DIN];
  assign fsel_fall = pin_fall[PIN_FSEL];
  assign sclk_fall = pin_fall[PIN_SCLK];

  sdac_frame_ctrl #(
    .FRAME_BITS (FRAME_BITS),
    .CODE_LSB   (CODE_LSB),
    .CODE_W     (CODE_W),
    .RSV_W      (RSV_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .fsel_lvl  (fsel_lvl),
    .fsel_fall (fsel_fall),
    .sclk_fall (sclk_fall),
    .din_bit   (din_bit),
    .commit_o  (frame_commit),
    .abort_o   (frame_abort),
    .code_o    (frame_code),
    .rsv_o     (frame_rsv)
  );

  sdac_code_hold #(
    .CODE_W    (CODE_W),
    .RSV_W     (RSV_W),
    .RESET_MID (RESET_MID)
  ) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit_i   (frame_commit),
    .code_i     (frame_code),
    .rsv_i      (frame_rsv),
    .code_o     (dac_code),
    .update_o   (dac_update),
    .rsv_flag_o (rsv_flag)
  );

  // Every commit gives a strobe in the next cycle (R4)
  assert_commit_strobes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_commit |=> dac_update);

  // An aborted frame gives no strobe (R5)
  assert_abort_no_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |=> !dac_update);

endmodule

// File: tb/sdac_frame_rx_test.sv
module sdac_frame_rx_test;

  logic clk    = 1'b0;
  logic rst_n  = 1'b0;
  logic fsel_n = 1'b1;
  logic sclk   = 1'b1;
  logic sdin   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  logic [17:0] code, code_mid;
  logic        upd, flag, upd_mid, flag_mid;

  sdac_frame_rx #(.RESET_MID(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .fsel_n(fsel_n), .sclk(sclk), .sdin(sdin),
    .dac_code(code), .dac_update(upd), .rsv_flag(flag));

  sdac_frame_rx #(.RESET_MID(1'b1)) uut_mid (
    .clk(clk), .rst_n(rst_n), .fsel_n(fsel_n), .sclk(sclk), .sdin(sdin),
    .dac_code(code_mid), .dac_update(upd_mid), .rsv_flag(flag_mid));

  int n_tests = 0;
  int n_fail  = 0;
  int strobes = 0;
  bit finished = 0;

  // ---------------- reference model ----------------
  // Pin samples {din, sclk, fsel}. An output reflects the samples taken 2 and 3 edges earlier.
  logic [2:0]  hist[$];
  int          mstate;   // 0 idle, 1 collecting, 2 done
  int          mcnt;
  logic [23:0] mframe;
  logic [17:0] exp_code, exp_code_mid;
  logic        exp_upd, exp_flag;

  always @(posedge clk) begin
    logic [2:0] cur, old;
    if (!rst_n) begin
      hist = '{3'b011, 3'b011, 3'b011, 3'b011};
      mstate = 0; mcnt = 0; mframe = '0;
      exp_code = '0; exp_code_mid = 18'h20000; exp_upd = 0; exp_flag = 0;
    end else begin
      hist.push_back({sdin, sclk, fsel_n});
      void'(hist.pop_front());
      cur = hist[1];
      old = hist[0];
      exp_upd = 0;
      case (mstate)
        0: if (old[0] && !cur[0]) begin mstate = 1; mcnt = 0; mframe = '0; end
        1: begin
          if (old[1] && !cur[1] && mcnt == 23) begin
            mframe = {mframe[22:0], cur[2]};
            exp_code = mframe[19:2];
            exp_code_mid = mframe[19:2];
            exp_flag = |mframe[21:20];
            exp_upd = 1;
            mstate = 2;
          end else if (cur[0]) begin
            mstate = 0;
          end else if (old[1] && !cur[1]) begin
            mframe = {mframe[22:0], cur[2]};
            mcnt++;
          end
        end
        default: if (cur[0]) mstate = 0;
      endcase
    end
  end

  // Every-clock comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      n_tests += 4;
      if (code !== exp_code) begin n_fail++;
        $display("FAIL R3 per-cycle code: actual %h expected %h", code, exp_code); end
      if (upd !== exp_upd) begin n_fail++;
        $display("FAIL R4 per-cycle strobe: actual %b expected %b", upd, exp_upd); end
      if (flag !== exp_flag) begin n_fail++;
        $display("FAIL R8 per-cycle flag: actual %b expected %b", flag, exp_flag); end
      if (code_mid !== exp_code_mid) begin n_fail++;
        $display("FAIL R1 per-cycle midscale code: actual %h expected %h", code_mid, exp_code_mid); end
      if (upd === 1'b1) strobes++;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [23:0] mk(input logic [1:0] top, input logic [1:0] rsv,
                                     input logic [17:0] c, input logic [1:0] lo);
    return {top, rsv, c, lo};
  endfunction

  // Sends the n low bits of w, MSB first, each bit taken on an sclk fall
  task automatic send(input logic [31:0] w, input int n, input bit rise);
    @(negedge clk);
    fsel_n = 1'b0;
    idle(4);
    for (int i = n - 1; i >= 0; i--) begin
      sdin = w[i];
      idle(4);
      sclk = 1'b0;
      idle(4);
      sclk = 1'b1;
    end
    idle(4);
    if (rise) begin
      fsel_n = 1'b1;
      idle(8);
    end
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog R4 run: actual hung expected complete");
      summary();
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    int s0;
    idle(5);
    rst_n = 1'b1;
    idle(2);

    // R1: reset values of both variants
    check("R1", "zero variant code", code, 0);
    check("R1", "midscale variant code", code_mid, 32'h20000);
    check("R1", "strobe", upd, 0);
    check("R1", "flag", flag, 0);

    // R2: clock activity with select high changes nothing
    s0 = strobes;
    for (int i = 0; i < 6; i++) begin
      sdin = 1'b1; idle(4); sclk = 1'b0; idle(4); sclk = 1'b1;
    end
    idle(8);
    check("R2", "code with select high", code, 0);
    check("R2", "strobes with select high", strobes, s0);

    // R3/R4: normal frame, don't-care bits set
    send(mk(2'b11, 2'b00, 18'h2B3C5, 2'b11), 24, 1);
    check("R3", "code", code, 32'h2B3C5);
    check("R4", "one strobe", strobes, s0 + 1);
    check("R8", "flag clear", flag, 0);
    check("R1", "midscale variant after write", code_mid, 32'h2B3C5);

    // R5: abort after 10 bits
    s0 = strobes;
    send(mk(2'b00, 2'b00, 18'h15555, 2'b00), 10, 1);
    check("R5", "code after short abort", code, 32'h2B3C5);
    check("R5", "no strobe after short abort", strobes, s0);

    // R5: abort after 23 bits
    send(mk(2'b00, 2'b00, 18'h0F0F0, 2'b00), 23, 1);
    check("R5", "code after 23-bit abort", code, 32'h2B3C5);
    check("R5", "no strobe after 23-bit abort", strobes, s0);

    // R3/R5: all-ones code after aborts, no leftover bits
    send(mk(2'b00, 2'b00, 18'h3FFFF, 2'b00), 24, 1);
    check("R3", "all-ones code", code, 32'h3FFFF);
    check("R5", "strobe after clean frame", strobes, s0 + 1);

    // R6: six extra falls after the 24th in one low period
    s0 = strobes;
    send({2'b00, mk(2'b00, 2'b00, 18'h00001, 2'b00), 6'b111111}, 30, 1);
    check("R6", "code ignores extra clocks", code, 32'h00001);
    check("R6", "single strobe with extra clocks", strobes, s0 + 1);

    // R7: select kept low after commit, then clocks, then rise
    s0 = strobes;
    send(mk(2'b00, 2'b00, 18'h12345, 2'b00), 24, 0);
    idle(40);
    check("R7", "code with select held low", code, 32'h12345);
    for (int i = 0; i < 4; i++) begin
      sdin = 1'b0; idle(4); sclk = 1'b0; idle(4); sclk = 1'b1;
    end
    idle(8);
    check("R6", "code after late clocks", code, 32'h12345);
    fsel_n = 1'b1;
    idle(10);
    check("R7", "code after select rise", code, 32'h12345);
    check("R7", "strobes for held frame", strobes, s0 + 1);

    // R8: reserved field nonzero is accepted and flagged; all-zero code boundary
    send(mk(2'b01, 2'b10, 18'h00000, 2'b10), 24, 1);
    check("R3", "all-zero code", code, 0);
    check("R8", "flag set", flag, 1);
    send(mk(2'b00, 2'b01, 18'h0ABCD, 2'b00), 24, 1);
    check("R8", "flag set low bit", flag, 1);
    check("R8", "code with reserved set", code, 32'h0ABCD);
    send(mk(2'b10, 2'b00, 18'h2AAAA, 2'b01), 24, 1);
    check("R8", "flag cleared", flag, 0);
    check("R8", "code with don't-cares", code, 32'h2AAAA);
    check("R1", "midscale variant follows", code_mid, 32'h2AAAA);

    idle(10);
    finished = 1;
    summary();
    $finish;
  end

endmodule